// File: doc/BRIEF.md
# Seven-to-One Pixel Lane Serializer

This block turns one parallel RGB pixel, with its display-enable and two sync flags, into four serial data lanes and one clock lane. It runs on the fast bit clock, which is seven times the pixel rate. Every pixel becomes a 7-bit frame on each lane. The clock lane repeats a fixed 7-bit pattern, so a receiver can recover the frame boundary and the pixel rate from it. The differential drivers and the clock multiplier that makes the bit clock sit outside the block.

Two static configuration inputs select the lane mapping. `cfg_wide` chooses 18-bit colour (0) or 24-bit colour (1). In 24-bit colour, `cfg_lo6` chooses where the bits go:
- With `cfg_lo6` = 0, the upper six bits of each component go on lanes 0 to 2, and the two lowest bits of each component go on lane 3.
- With `cfg_lo6` = 1, the low six bits of each component go on lanes 0 to 2 exactly as in 18-bit mode, and the two top bits go on lane 3.

The block takes the pixel and the configuration at one edge per frame only. At that same edge it loads the shift registers, so frames follow each other with no gap.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: While `rst_n` is low, `lane_data_o` is 0000 and `lane_clk_o` is 1. The release of `rst_n` takes effect on the third rising bit-clock edge after `rst_n` rises. The first captured pixel is sampled at the ninth rising edge after the rise, and its bit 1 is on the lanes right after that edge.
- R2: `lane_clk_o` repeats the bit pattern 1,1,0,0,0,1,1. Each of these bits aligns with bits 1 to 7 of the data frames.
- R3: Each frame puts one bit per bit clock on each lane, bit 1 first and bit 7 last. The next frame's bit 1 follows bit 7 on the very next bit clock.
- R4: With `cfg_wide` = 0, components use bits [5:0], and bits 1 to 7 are as follows. Lane 0: G0,R5,R4,R3,R2,R1,R0. Lane 1: B1,B0,G5,G4,G3,G2,G1. Lane 2: DE,VSYNC,HSYNC,B5,B4,B3,B2.
- R5: With `cfg_wide` = 0, lane 3 stays at 0 for the whole frame.
- R6: With `cfg_wide` = 1 and `cfg_lo6` = 0, lanes 0 to 2 follow the R4 layout with component bits [7:2] standing in for [5:0]. For example, lane 0 is G2,R7,R6,R5,R4,R3,R2. Lane 3 is 0,B1,B0,G1,G0,R1,R0.
- R7: With `cfg_wide` = 1 and `cfg_lo6` = 1, lanes 0 to 2 follow the R4 layout using bits [5:0]. Lane 3 is 0,B7,B6,G7,G6,R7,R6.
- R8: When `cfg_wide` = 0, the value of `cfg_lo6` has no effect on any lane.
- R9: Pixel, DE and sync inputs are sampled only at the edge that ends bit 7 of a frame. Changes at any other edge do not alter the emitted bits.
- R10: `cfg_wide` and `cfg_lo6` are sampled only at that same frame edge. Toggling them mid-frame never gives a frame with a mixed mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wide | input | 1 | 1 selects 24-bit colour, 0 selects 18-bit colour |
| cfg_lo6 | input | 1 | In 24-bit colour, 1 puts the low six component bits on lanes 0 to 2 |
| pix_red | input | COLOR_W | Red component |
| pix_grn | input | COLOR_W | Green component |
| pix_blu | input | COLOR_W | Blue component |
| pix_de | input | 1 | Display enable |
| pix_hsync | input | 1 | Horizontal sync |
| pix_vsync | input | 1 | Vertical sync |
| lane_data_o | output | 4 | Serial data lanes 0 to 3 |
| lane_clk_o | output | 1 | Serial clock lane pattern |

## Verification
The bench builds the block with `COLOR_W` = 8. This is the width at which all three mappings exist, and at which lane 3 carries real extension bits in both 24-bit layouts. With full-width components, the random pixels drive every colour bit to both values in every lane position. Driving the configuration pins every cycle reaches frames whose mapping would be torn if the settings were sampled at any edge other than the frame edge.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

  // Bits per lane per pixel.
  localparam int unsigned FRAME_BITS = 7;
  // Serial data lanes on one link.
  localparam int unsigned DATA_LANES = 4;
  // Width of the in-frame bit index.
  localparam int unsigned BIT_IDX_W  = $clog2(FRAME_BITS);
  // Clock lane word, MSB leaves first.
  localparam logic [FRAME_BITS-1:0] CLK_LANE_WORD = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_18     = 2'd0,
    MAP_24_HI6 = 2'd1,
    MAP_24_LO6 = 2'd2
  } lane_map_e;

endpackage

// File: rtl/lvds_rst_sync.sv
module lvds_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/lvds_bit_counter.sv
module lvds_bit_counter #(
  parameter int unsigned FRAME_BITS = 7,
  parameter int unsigned IDX_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             at_last;

  always_comb begin
    at_last = (idx_q == LAST_IDX);
    idx_d   = at_last ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = at_last;

endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
  import lvds_ser_pkg::*;
#(
  parameter int unsigned COLOR_W = 8
) (
  input  logic [COLOR_W-1:0]                   red_i,
  input  logic [COLOR_W-1:0]                   grn_i,
  input  logic [COLOR_W-1:0]                   blu_i,
  input  logic                                 de_i,
  input  logic                                 hs_i,
  input  logic                                 vs_i,
  input  lane_map_e                            map_i,
  output logic [DATA_LANES-1:0][FRAME_BITS-1:0] word_o
);

  localparam int unsigned CORE_W = 6;
  localparam int unsigned EXT_W  = COLOR_W - CORE_W;

  logic [CORE_W-1:0] r_core, g_core, b_core;
  logic [EXT_W-1:0]  r_ext, g_ext, b_ext;

  // Select which slice of each component rides on lanes 0..2 and lane 3.
  always_comb begin
    if (map_i == MAP_24_HI6) begin
      r_core = red_i[COLOR_W-1 -: CORE_W];
      g_core = grn_i[COLOR_W-1 -: CORE_W];
      b_core = blu_i[COLOR_W-1 -: CORE_W];
      r_ext  = red_i[EXT_W-1:0];
      g_ext  = grn_i[EXT_W-1:0];
      b_ext  = blu_i[EXT_W-1:0];
    end else begin
      r_core = red_i[CORE_W-1:0];
      g_core = grn_i[CORE_W-1:0];
      b_core = blu_i[CORE_W-1:0];
      r_ext  = red_i[COLOR_W-1 -: EXT_W];
      g_ext  = grn_i[COLOR_W-1 -: EXT_W];
      b_ext  = blu_i[COLOR_W-1 -: EXT_W];
    end
  end

  // Word MSB is frame bit 1.
  always_comb begin
    word_o[0] = {g_core[0], r_core};
    word_o[1] = {b_core[1:0], g_core[CORE_W-1:1]};
    word_o[2] = {de_i, vs_i, hs_i, b_core[CORE_W-1:2]};
    if (map_i == MAP_18) begin
      word_o[3] = '0;
    end else begin
      word_o[3] = {1'b0, b_ext, g_ext, r_ext};
    end
  end

endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter #(
  parameter int unsigned             FRAME_BITS = 7,
  parameter logic [FRAME_BITS-1:0]   RST_WORD   = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] word_i,
  output logic                  ser_o
);

  logic [FRAME_BITS-1:0] sh_q;
  logic [FRAME_BITS-1:0] sh_d;

  always_comb begin
    if (load_i) begin
      sh_d = word_i;
    end else begin
      sh_d = {sh_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= RST_WORD;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign ser_o = sh_q[FRAME_BITS-1];

endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
#(
  parameter int unsigned COLOR_W = 8
) (
  input  logic                  clk_bit,
  input  logic                  rst_n,
  input  logic                  cfg_wide,
  input  logic                  cfg_lo6,
  input  logic [COLOR_W-1:0]    pix_red,
  input  logic [COLOR_W-1:0]    pix_grn,
  input  logic [COLOR_W-1:0]    pix_blu,
  input  logic                  pix_de,
  input  logic                  pix_hsync,
  input  logic                  pix_vsync,
  output logic [DATA_LANES-1:0] lane_data_o,
  output logic                  lane_clk_o
);

  logic                                  rst_n_core;
  logic [BIT_IDX_W-1:0]                  bit_idx;
  logic                                  frame_last;
  lane_map_e                             map_sel;
  logic [DATA_LANES-1:0][FRAME_BITS-1:0] lane_word;

  lvds_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk_bit),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_core)
  );

  lvds_bit_counter #(.FRAME_BITS(FRAME_BITS), .IDX_W(BIT_IDX_W)) u_bit_cnt (
    .clk    (clk_bit),
    .rst_n  (rst_n_core),
    .idx_o  (bit_idx),
    .last_o (frame_last)
  );

  // Configuration decode; only consumed on the frame-load edge.
  always_comb begin
    if (!cfg_wide) begin
      map_sel = MAP_18;
    end else if (cfg_lo6) begin
      map_sel = MAP_24_LO6;
    end else begin
      map_sel = MAP_24_HI6;
    end
  end

  lvds_lane_mapper #(.COLOR_W(COLOR_W)) u_mapper (
    .red_i  (pix_red),
    .grn_i  (pix_grn),
    .blu_i  (pix_blu),
    .de_i   (pix_de),
    .hs_i   (pix_hsync),
    .vs_i   (pix_vsync),
    .map_i  (map_sel),
    .word_o (lane_word)
  );

  for (genvar ln = 0; ln < DATA_LANES; ln++) begin : g_data_lane
    lvds_lane_shifter #(
      .FRAME_BITS (FRAME_BITS),
      .RST_WORD   ({FRAME_BITS{1'b0}})
    ) u_shift (
      .clk    (clk_bit),
      .rst_n  (rst_n_core),
      .load_i (frame_last),
      .word_i (lane_word[ln]),
      .ser_o  (lane_data_o[ln])
    );
  end

  lvds_lane_shifter #(
    .FRAME_BITS (FRAME_BITS),
    .RST_WORD   (CLK_LANE_WORD)
  ) u_clk_shift (
    .clk    (clk_bit),
    .rst_n  (rst_n_core),
    .load_i (frame_last),
    .word_i (CLK_LANE_WORD),
    .ser_o  (lane_clk_o)
  );

endmodule

// File: rtl/lvds_pixel_serializer_chk.sv
module lvds_pixel_serializer_chk
  import lvds_ser_pkg::*;
(
  input logic                  clk_bit,
  input logic                  rst_n,
  input logic                  cfg_wide,
  input logic [DATA_LANES-1:0] lane_data_o,
  input logic                  lane_clk_o,
  input logic [BIT_IDX_W-1:0]  bit_idx
);

  localparam logic [BIT_IDX_W-1:0] LAST_IDX = BIT_IDX_W'(FRAME_BITS - 1);

  logic [7:0] cyc_q;
  logic       frame18_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (cyc_q != 8'hFF) begin
      cyc_q <= cyc_q + 8'd1;
    end
  end

  // Mode of the frame currently on the lanes, tracked from the pins.
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      frame18_q <= 1'b1;
    end else if (bit_idx == LAST_IDX && cyc_q >= 8'd2) begin
      frame18_q <= !cfg_wide;
    end
  end

  p_idx_range_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
    bit_idx <= LAST_IDX);

  p_idx_step_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (cyc_q >= 8'd2 && bit_idx != LAST_IDX) |=> bit_idx == BIT_IDX_W'($past(bit_idx) + 1'b1));

  p_idx_wrap_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (bit_idx == LAST_IDX) |=> bit_idx == '0);

  p_clk_mid_low_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (bit_idx >= 2 && bit_idx <= 4) |-> !lane_clk_o);

  p_clk_period_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (cyc_q >= 8'd10) |-> lane_clk_o == $past(lane_clk_o, 7));

  p_lane3_idle_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
    frame18_q |-> !lane_data_o[3]);

  // Reserved first bit of lane 3 in both wide layouts (R6, R7).
  p_lane3_rsvd_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (bit_idx == '0) |-> !lane_data_o[3]);

endmodule

bind lvds_pixel_serializer lvds_pixel_serializer_chk u_chk (
  .clk_bit     (clk_bit),
  .rst_n       (rst_n),
  .cfg_wide    (cfg_wide),
  .lane_data_o (lane_data_o),
  .lane_clk_o  (lane_clk_o),
  .bit_idx     (bit_idx)
);

// File: tb/lvds_pixel_serializer_bench.sv
module lvds_pixel_serializer_bench;

  localparam int CW = 8;

  logic          clk_bit = 1'b0;
  logic          rst_n;
  logic          cfg_wide, cfg_lo6;
  logic [CW-1:0] pix_red, pix_grn, pix_blu;
  logic          pix_de, pix_hsync, pix_vsync;
  logic [3:0]    lane_data_o;
  logic          lane_clk_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    started = 1'b0;
  bit    finished = 1'b0;
  string cur_tag = "R1";

  always #2.5 clk_bit = ~clk_bit;

  lvds_pixel_serializer #(.COLOR_W(CW)) u_lvds_pixel_serializer (
    .clk_bit, .rst_n, .cfg_wide, .cfg_lo6, .pix_red, .pix_grn, .pix_blu,
    .pix_de, .pix_hsync, .pix_vsync, .lane_data_o, .lane_clk_o
  );

  // Reference model state: bit position 1..7 and the frame being sent.
  int          m_bit, m_rel, f_mode;
  logic [7:0]  f_r, f_g, f_b;
  logic        f_de, f_hs, f_vs;

  function automatic int decode_mode(logic w, logic lo);
    if (!w) return 0;
    return lo ? 2 : 1;
  endfunction

  // Expected bit b (1..7) on lane ln for mode md (0:18, 1:wide hi6, 2:wide lo6).
  function automatic logic exp_bit(int ln, int b, int md, logic [7:0] r,
                                   logic [7:0] g, logic [7:0] bl,
                                   logic de, logic hs, logic vs);
    int off, eb;
    off = (md == 1) ? 2 : 0;
    eb  = (md == 1) ? 0 : 6;
    case (ln)
      0: return (b == 1) ? g[off] : r[off + 7 - b];
      1: if (b == 1) return bl[off + 1];
         else if (b == 2) return bl[off];
         else return g[off + 8 - b];
      2: if (b == 1) return de;
         else if (b == 2) return vs;
         else if (b == 3) return hs;
         else return bl[off + 9 - b];
      default: begin
        if (md == 0 || b == 1) return 1'b0;
        case (b)
          2: return bl[eb + 1];
          3: return bl[eb];
          4: return g[eb + 1];
          5: return g[eb];
          6: return r[eb + 1];
          default: return r[eb];
        endcase
      end
    endcase
  endfunction

  always @(posedge clk_bit) begin
    if (!rst_n || m_rel < 2) begin
      if (!rst_n) m_rel = 0; else m_rel++;
      m_bit = 1; f_mode = 0;
      f_r = '0; f_g = '0; f_b = '0; f_de = 0; f_hs = 0; f_vs = 0;
    end else if (m_bit == 7) begin
      m_bit = 1;
      f_mode = decode_mode(cfg_wide, cfg_lo6);
      f_r = pix_red; f_g = pix_grn; f_b = pix_blu;
      f_de = pix_de; f_hs = pix_hsync; f_vs = pix_vsync;
    end else begin
      m_bit++;
    end
    started = 1'b1;
  end

  task automatic check_bit(string tag, int ln, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s lane%0d bit%0d got %0b exp %0b", tag, ln, m_bit, got, exp);
    end
  endtask

  // Compare every lane on every cycle, away from the rising edge.
  always @(negedge clk_bit) begin
    if (started && rst_n && !finished) begin
      for (int ln = 0; ln < 4; ln++) begin
        string mt;
        mt = (f_mode == 0) ? ((ln == 3) ? "R5" : "R4") : ((f_mode == 1) ? "R6" : "R7");
        check_bit($sformatf("%s/%s", mt, cur_tag), ln, lane_data_o[ln],
                  exp_bit(ln, m_bit, f_mode, f_r, f_g, f_b, f_de, f_hs, f_vs));
      end
      check_bit($sformatf("R2/%s", cur_tag), 4, lane_clk_o,
                (m_bit <= 2 || m_bit >= 6) ? 1'b1 : 1'b0);
    end
  end

  task automatic rand_pix();
    pix_red = 8'($urandom); pix_grn = 8'($urandom); pix_blu = 8'($urandom);
    pix_de = 1'($urandom); pix_hsync = 1'($urandom); pix_vsync = 1'($urandom);
  endtask

  task automatic run(int n, bit pix_fast, bit cfg_fast, string tag);
    cur_tag = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_bit);
      if (pix_fast || (i % 7) == 0) rand_pix();
      if (cfg_fast) begin
        cfg_wide = 1'($urandom);
        cfg_lo6  = 1'($urandom);
      end
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(60000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog expired got hang exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wide = 1'b0; cfg_lo6 = 1'b0;
    pix_red = 8'hFF; pix_grn = 8'hFF; pix_blu = 8'hFF;
    pix_de = 1; pix_hsync = 1; pix_vsync = 1;
    // R1: idle levels during reset.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_bit);
      n_chk++;
      if (lane_data_o !== 4'b0000 || lane_clk_o !== 1'b1) begin
        n_fail++;
        $display("FAIL R1 reset lanes got %b/%b exp 0000/1", lane_data_o, lane_clk_o);
      end
    end
    rst_n = 1'b1;
    run(21, 1'b0, 1'b0, "R1");
    run(70, 1'b0, 1'b0, "R3");
    run(70, 1'b1, 1'b0, "R9");
    cfg_lo6 = 1'b1;
    run(70, 1'b1, 1'b0, "R8");
    cfg_wide = 1'b1; cfg_lo6 = 1'b0;
    run(140, 1'b1, 1'b0, "R9");
    cfg_lo6 = 1'b1;
    run(140, 1'b1, 1'b0, "R9");
    run(700, 1'b1, 1'b1, "R10");
    cfg_wide = 1'b0;
    run(28, 1'b0, 1'b0, "R3");
    summary();
    $finish;
  end

endmodule